// File: doc/BRIEF.md
# Serial Row-Programming Sequencer

This block reprograms a nonvolatile logic array that sits behind a five-wire serial programming port. When software or a host controller pulses `start`, the sequencer reads a packed fuse image from a byte-wide memory. It first parses a seven-byte header. It then raises the port enable and erases the whole device with a timed pulse. After that it programs the array one row at a time.

A single 1 is walked through the target's address shift register to pick the row being written. Each row's cells are shifted into the target's data register as two separate halves, low half first. A timed program pulse then commits the row. The erase and program pulse widths are header values counted in millisecond ticks. A prescaler parameter sets the tick, so a test can use a very short one.

When the last row has been committed, the enable drops and `done` goes high. The sequencer raises `error` and releases the port if any of these happens:
- the image ends early;
- the header describes an empty array;
- the target reports not-ready after a pulse.

Top module: `rowprog_seq`

## Requirements
- R1: `prog_en` is high from the first erase command until the run ends and low at all other times. Whenever `prog_en` is low, `prog_sclk` and `prog_mode` are both low.
- R2: The image starts with a seven-byte header:
  - byte 0: device type, presented on `dev_type`;
  - bytes 1 and 2: erase width, little-endian;
  - bytes 3 and 4: program width, little-endian;
  - byte 5: row count;
  - byte 6: half-row length in bytes.

  Fuse data follows from byte 7. Each row holds its low-half bytes and then its high-half bytes, and every byte is sent LSB first. Memory reads (`mem_rd`) occur only while busy, and data arrives one cycle after the read.
- R3: Every command is a 3-bit opcode shifted LSB first with `prog_mode` high. The opcodes are: erase=1, address=2, data-low=3, data-high=4, program=5. Any payload then follows with `prog_mode` low. `prog_mode` does not change while `prog_sclk` is high.
- R4: `prog_sdi` changes only while `prog_sclk` is low, and each phase of `prog_sclk` lasts `SCLK_HALF` clock cycles.
- R5: The command order is:
  1. erase;
  2. address with the single payload bit 1, which selects row 0;
  3. then for each row: data-low, data-high, program;
  4. between consecutive rows, address with the single payload bit 0, which moves the selected row by exactly one.

  At every program pulse the address register is one-hot at the current row, and both halves hold the row's fuse bits.
- R6: An erase or program pulse keeps `prog_mode` and `prog_sclk` low for the width taken from the header (a count of ms ticks) times `TICK_CYC` cycles. The measured pulse is between that product and that product plus 3 cycles.
- R7: `prog_sdo` is sampled after each pulse. If it is low, the run stops with `error`, and no later command is issued.
- R8: If a byte is needed at an address at or beyond `mem_len`, the run stops with `error` and `done` stays low. No program pulse is issued for the incomplete row.
- R9: A header with a row count of 0, or a half-row length of 0, ends the run with `error` and `prog_en` never rises.
- R10: A `start` pulse while `busy` is high is ignored. The ongoing run completes with exactly the same command sequence.
- R11: After reset, `busy`, `done`, `error`, `prog_en`, `prog_sclk` and `mem_rd` are all low. `done` and `error` are never high together. Both flags hold their value until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (single-cycle pulse) |
| mem_rd | output | 1 | Image memory read strobe |
| mem_addr | output | ADDR_W | Image memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| mem_len | input | ADDR_W+1 | Number of valid image bytes |
| prog_en | output | 1 | Programming enable to target |
| prog_mode | output | 1 | High while an opcode is shifted |
| prog_sdi | output | 1 | Serial data to target |
| prog_sclk | output | 1 | Serial clock to target |
| prog_sdo | input | 1 | Target ready/serial return |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed successfully |
| error | output | 1 | Last run aborted |
| dev_type | output | 8 | Device type byte from the header |

## Verification
The bench models the target behaviourally. It checks three things at each program pulse:
- the address register is one-hot at the expected row (a design that walks the 1 wrongly, or reloads it, programs the wrong row);
- the low and high halves hold their own bytes (swapped halves or a bad byte order corrupt fuse bits);
- the pulse length matches the header width (a design that reads the wrong header byte or the wrong byte order gives pulses far too short or too long).

Further scenarios cover:
- a single-row image, which must issue no address advance;
- an image one byte short, which must stop before the last program pulse;
- an empty header, which must never enable the port;
- a not-ready target, which must stop the run after the erase;
- a second start during a run, which a careless design would accept and so restart the erase.

// File: rtl/rowprog_pkg.sv
package rowprog_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ERASE = 3'd1,
    OP_ADDR  = 3'd2,
    OP_LO    = 3'd3,
    OP_HI    = 3'd4,
    OP_PROG  = 3'd5
  } opcode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HRD, S_HCAP, S_OPC_GO, S_OPC_WAIT, S_PAY_GO,
    S_PAY_WAIT, S_PULSE, S_CHECK, S_FRD, S_FCAP
  } state_e;

  localparam int HDR_LAST = 6;
  localparam int OPC_BITS = 3;
endpackage

// File: rtl/rowprog_shift.sv
module rowprog_shift #(
  parameter int HALF_DIV = 4,
  parameter int W        = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [W-1:0]           din,
  input  logic [$clog2(W+1)-1:0] nbits,
  output logic                   sclk,
  output logic                   sdi,
  output logic                   done
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int NW = $clog2(W+1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  sh_q, sh_n;
  logic [NW-1:0] left_q, left_n;
  logic          act_q, act_n, sclk_q, sclk_n, sdi_q, sdi_n, done_q, done_n;

  always_comb begin
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    left_n = left_q;
    act_n  = act_q;
    sclk_n = sclk_q;
    sdi_n  = sdi_q;
    done_n = 1'b0;
    if (start) begin
      sh_n   = din;
      left_n = nbits;
      sdi_n  = din[0];
      sclk_n = 1'b0;
      cnt_n  = '0;
      act_n  = 1'b1;
    end else if (act_q) begin
      if (cnt_q == CW'(HALF_DIV-1)) begin
        cnt_n = '0;
        if (!sclk_q) begin
          sclk_n = 1'b1;
        end else begin
          sclk_n = 1'b0;
          if (left_q == NW'(1)) begin
            act_n  = 1'b0;
            done_n = 1'b1;
          end else begin
            left_n = left_q - NW'(1);
            sh_n   = sh_q >> 1;
            sdi_n  = sh_q[1];
          end
        end
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      left_q <= '0;
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      sdi_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      left_q <= left_n;
      act_q  <= act_n;
      sclk_q <= sclk_n;
      sdi_q  <= sdi_n;
      done_q <= done_n;
    end
  end

  assign sclk = sclk_q;
  assign sdi  = sdi_q;
  assign done = done_q;
endmodule

// File: rtl/rowprog_timer.sv
module rowprog_timer #(
  parameter int TICK_CYC = 50000,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] width,
  output logic             expired
);
  localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

  logic             act_q, act_n;
  logic [CNT_W-1:0] ms_q, ms_n;
  logic [TW-1:0]    cyc_q, cyc_n;

  always_comb begin
    act_n = act_q;
    ms_n  = ms_q;
    cyc_n = cyc_q;
    if (start) begin
      act_n = 1'b1;
      ms_n  = width;
      cyc_n = '0;
    end else if (act_q) begin
      if (ms_q == '0) begin
        act_n = 1'b0;
      end else if (cyc_q == TW'(TICK_CYC-1)) begin
        cyc_n = '0;
        ms_n  = ms_q - CNT_W'(1);
      end else begin
        cyc_n = cyc_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ms_q  <= '0;
      cyc_q <= '0;
    end else begin
      act_q <= act_n;
      ms_q  <= ms_n;
      cyc_q <= cyc_n;
    end
  end

  assign expired = act_q && (ms_q == '0);
endmodule

// File: rtl/rowprog_ctrl.sv
module rowprog_ctrl
  import rowprog_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W:0]   mem_len,
  input  logic [7:0]        mem_rdata,
  input  logic              sdo,
  input  logic              sh_done,
  input  logic              tmr_expired,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              sh_start,
  output logic [7:0]        sh_din,
  output logic [3:0]        sh_nbits,
  output logic              tmr_start,
  output logic [15:0]       tmr_width,
  output logic              prog_en,
  output logic              prog_mode,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [7:0]        dev_type
);
  state_e        st_q, st_n;
  opcode_e       op_q, op_n;
  logic          abit_q, abit_n, en_q, en_n, mode_q, mode_n;
  logic          done_q, done_n, err_q, err_n;
  logic [ADDR_W:0] ptr_q, ptr_n;
  logic [7:0]    row_q, row_n, nrows_q, nrows_n, hb_q, hb_n, bcnt_q, bcnt_n;
  logic [7:0]    dev_q, dev_n, pay_q, pay_n;
  logic [15:0]   ew_q, ew_n, pw_q, pw_n;
  logic          mem_end;

  assign mem_end = (ptr_q >= mem_len);

  always_comb begin
    st_n = st_q;   op_n = op_q;   abit_n = abit_q; en_n = en_q;
    done_n = done_q; err_n = err_q; ptr_n = ptr_q; row_n = row_q;
    nrows_n = nrows_q; hb_n = hb_q; bcnt_n = bcnt_q; dev_n = dev_q;
    pay_n = pay_q; ew_n = ew_q; pw_n = pw_q;
    mem_rd = 1'b0; sh_start = 1'b0; tmr_start = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        done_n = 1'b0; err_n = 1'b0; ptr_n = '0; row_n = '0;
        st_n = S_HRD;
      end
      S_HRD: if (mem_end) begin
        err_n = 1'b1; st_n = S_IDLE;
      end else begin
        mem_rd = 1'b1; st_n = S_HCAP;
      end
      S_HCAP: begin
        ptr_n = ptr_q + 1'b1;
        case (ptr_q[2:0])
          3'd0: dev_n = mem_rdata;
          3'd1: ew_n[7:0] = mem_rdata;
          3'd2: ew_n[15:8] = mem_rdata;
          3'd3: pw_n[7:0] = mem_rdata;
          3'd4: pw_n[15:8] = mem_rdata;
          3'd5: nrows_n = mem_rdata;
          default: hb_n = mem_rdata;
        endcase
        if (ptr_q[2:0] == 3'(HDR_LAST)) begin
          if (nrows_q == '0 || mem_rdata == '0) begin
            err_n = 1'b1; st_n = S_IDLE;
          end else begin
            en_n = 1'b1; op_n = OP_ERASE; st_n = S_OPC_GO;
          end
        end else begin
          st_n = S_HRD;
        end
      end
      S_OPC_GO: begin
        sh_start = 1'b1; st_n = S_OPC_WAIT;
      end
      S_OPC_WAIT: if (sh_done) begin
        case (op_q)
          OP_ERASE, OP_PROG: begin tmr_start = 1'b1; st_n = S_PULSE; end
          OP_ADDR:           st_n = S_PAY_GO;
          default:           st_n = S_FRD;
        endcase
      end
      S_PAY_GO: begin
        sh_start = 1'b1; st_n = S_PAY_WAIT;
      end
      S_PAY_WAIT: if (sh_done) begin
        if (op_q == OP_ADDR) begin
          op_n = OP_LO; bcnt_n = '0; st_n = S_OPC_GO;
        end else if (bcnt_q == hb_q - 8'd1) begin
          bcnt_n = '0;
          op_n = (op_q == OP_LO) ? OP_HI : OP_PROG;
          st_n = S_OPC_GO;
        end else begin
          bcnt_n = bcnt_q + 8'd1; st_n = S_FRD;
        end
      end
      S_FRD: if (mem_end) begin
        err_n = 1'b1; en_n = 1'b0; st_n = S_IDLE;
      end else begin
        mem_rd = 1'b1; st_n = S_FCAP;
      end
      S_FCAP: begin
        pay_n = mem_rdata; ptr_n = ptr_q + 1'b1; st_n = S_PAY_GO;
      end
      S_PULSE: if (tmr_expired) st_n = S_CHECK;
      S_CHECK: if (!sdo) begin
        err_n = 1'b1; en_n = 1'b0; st_n = S_IDLE;
      end else if (op_q == OP_ERASE) begin
        op_n = OP_ADDR; abit_n = 1'b1; st_n = S_OPC_GO;
      end else if (row_q == nrows_q - 8'd1) begin
        done_n = 1'b1; en_n = 1'b0; st_n = S_IDLE;
      end else begin
        row_n = row_q + 8'd1; op_n = OP_ADDR; abit_n = 1'b0; st_n = S_OPC_GO;
      end
      default: st_n = S_IDLE;
    endcase
    mode_n = (st_n == S_OPC_GO) || (st_n == S_OPC_WAIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; op_q <= OP_NONE; abit_q <= 1'b0; en_q <= 1'b0;
      mode_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; ptr_q <= '0;
      row_q <= '0; nrows_q <= '0; hb_q <= '0; bcnt_q <= '0;
      dev_q <= '0; pay_q <= '0; ew_q <= '0; pw_q <= '0;
    end else begin
      st_q <= st_n; op_q <= op_n; abit_q <= abit_n; en_q <= en_n;
      mode_q <= mode_n; done_q <= done_n; err_q <= err_n; ptr_q <= ptr_n;
      row_q <= row_n; nrows_q <= nrows_n; hb_q <= hb_n; bcnt_q <= bcnt_n;
      dev_q <= dev_n; pay_q <= pay_n; ew_q <= ew_n; pw_q <= pw_n;
    end
  end

  assign mem_addr  = ptr_q[ADDR_W-1:0];
  assign sh_din    = (st_q == S_OPC_GO) ? {5'b0, op_q} :
                     (op_q == OP_ADDR)  ? {7'b0, abit_q} : pay_q;
  assign sh_nbits  = (st_q == S_OPC_GO) ? 4'(OPC_BITS) :
                     (op_q == OP_ADDR)  ? 4'd1 : 4'd8;
  assign tmr_width = (op_q == OP_ERASE) ? ew_q : pw_q;
  assign prog_en   = en_q;
  assign prog_mode = mode_q;
  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign error     = err_q;
  assign dev_type  = dev_q;
endmodule

// File: rtl/rowprog_seq.sv
module rowprog_seq #(
  parameter int ADDR_W    = 16,
  parameter int SCLK_HALF = 4,
  parameter int TICK_CYC  = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic [ADDR_W:0]   mem_len,
  output logic              prog_en,
  output logic              prog_mode,
  output logic              prog_sdi,
  output logic              prog_sclk,
  input  logic              prog_sdo,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [7:0]        dev_type
);
  logic [1:0]  rst_sync_q;
  logic        rst_s;
  logic        sh_start, sh_done, tmr_start, tmr_expired;
  logic [7:0]  sh_din;
  logic [3:0]  sh_nbits;
  logic [15:0] tmr_width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  rowprog_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .start(start), .mem_len(mem_len),
    .mem_rdata(mem_rdata), .sdo(prog_sdo), .sh_done(sh_done),
    .tmr_expired(tmr_expired), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .sh_start(sh_start), .sh_din(sh_din), .sh_nbits(sh_nbits),
    .tmr_start(tmr_start), .tmr_width(tmr_width), .prog_en(prog_en),
    .prog_mode(prog_mode), .busy(busy), .done(done), .error(error),
    .dev_type(dev_type)
  );

  rowprog_shift #(.HALF_DIV(SCLK_HALF), .W(8)) u_shift (
    .clk(clk), .rst_n(rst_s), .start(sh_start), .din(sh_din),
    .nbits(sh_nbits), .sclk(prog_sclk), .sdi(prog_sdi), .done(sh_done)
  );

  rowprog_timer #(.TICK_CYC(TICK_CYC), .CNT_W(16)) u_timer (
    .clk(clk), .rst_n(rst_s), .start(tmr_start), .width(tmr_width),
    .expired(tmr_expired)
  );
endmodule

// File: rtl/rowprog_chk.sv
module rowprog_chk (
  input logic clk,
  input logic rst_n,
  input logic prog_en,
  input logic prog_mode,
  input logic prog_sdi,
  input logic prog_sclk,
  input logic busy,
  input logic done,
  input logic error,
  input logic mem_rd
);
  assert_sdi_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_sclk && $past(prog_sclk)) |-> $stable(prog_sdi));
  assert_mode_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_sclk && $past(prog_sclk)) |-> $stable(prog_mode));
  assert_port_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |-> (!prog_sclk && !prog_mode));
  assert_idle_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !prog_en);
  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  assert_read_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);
endmodule

bind rowprog_seq rowprog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_mode(prog_mode),
  .prog_sdi(prog_sdi), .prog_sclk(prog_sclk), .busy(busy), .done(done),
  .error(error), .mem_rd(mem_rd)
);

// File: tb/tb_rowprog_seq.sv
module tb_rowprog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 9;
  localparam int HALF = 2;
  localparam int TICK = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tgt_ready = 1'b1;
  logic mem_rd, prog_en, prog_mode, prog_sdi, prog_sclk, busy, done, error;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00, dev_type;
  logic [AW:0] mem_len = '0;
  logic [7:0] mem [0:511];

  int n_chk = 0, n_fail = 0, cyc = 0;
  int cur_ew, cur_pw, cur_rows, cur_hb;
  int prog_cnt, erase_cnt, en_rises, pulse_len, pulse_op;
  bit in_pulse;
  logic [2:0] opc;
  int opc_bits;
  logic [255:0] tgt_addr;
  bit lo_q[$], hi_q[$];
  int ops_seen[$];
  logic p_sclk, p_mode, p_sdi, p_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  rowprog_seq #(.ADDR_W(AW), .SCLK_HALF(HALF), .TICK_CYC(TICK)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_len(mem_len),
    .prog_en(prog_en), .prog_mode(prog_mode), .prog_sdi(prog_sdi),
    .prog_sclk(prog_sclk), .prog_sdo(tgt_ready), .busy(busy), .done(done),
    .error(error), .dev_type(dev_type)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic end_pulse();
    int w, bad;
    w = (pulse_op == 1) ? cur_ew : cur_pw;
    chk(pulse_len >= w*TICK && pulse_len <= w*TICK+3, "R6 pulse length", pulse_len, w*TICK);
    if (pulse_op == 1) begin
      chk(prog_cnt == 0 && erase_cnt == 0, "R5 single erase first", erase_cnt, 0);
      erase_cnt++;
    end else begin
      chk(tgt_addr == (256'b1 << prog_cnt), "R5 one-hot row select",
          $countones(tgt_addr), 1);
      chk(lo_q.size() == cur_hb*8 && hi_q.size() == cur_hb*8, "R2 half lengths",
          lo_q.size() + hi_q.size(), cur_hb*16);
      bad = 0;
      if (lo_q.size() == cur_hb*8 && hi_q.size() == cur_hb*8)
        for (int k = 0; k < cur_hb*8; k++) begin
          if (lo_q[k] != mem[7 + prog_cnt*2*cur_hb + k/8][k%8]) bad++;
          if (hi_q[k] != mem[7 + prog_cnt*2*cur_hb + cur_hb + k/8][k%8]) bad++;
        end
      chk(bad == 0, "R2 row fuse bits", bad, 0);
      prog_cnt++;
      lo_q.delete();
      hi_q.delete();
    end
    in_pulse = 0;
  endtask

  // behavioural target and per-clock port checks
  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
    if (!rst_n) begin
      p_sclk = 0; p_mode = 0; p_sdi = 0; p_en = 0; in_pulse = 0; opc = '0; opc_bits = 0;
    end else begin
      if (prog_sclk && p_sclk) begin
        chk(prog_sdi == p_sdi, "R4 sdi held high phase", prog_sdi, p_sdi);
        chk(prog_mode == p_mode, "R3 mode held high phase", prog_mode, p_mode);
      end
      if (!prog_en) chk(!prog_sclk && !prog_mode, "R1 port quiet when disabled", prog_sclk, 0);
      if (prog_en && !p_en) begin tgt_addr = '0; en_rises++; end
      if (in_pulse && (prog_mode || !prog_en)) end_pulse();
      else if (in_pulse) begin
        pulse_len++;
        chk(!prog_sclk, "R6 clock idle in pulse", prog_sclk, 0);
      end
      if (prog_mode && !p_mode) opc_bits = 0;
      if (prog_sclk && !p_sclk && prog_en) begin
        if (prog_mode) begin opc = {prog_sdi, opc[2:1]}; opc_bits++; end
        else case (opc)
          3'd2: tgt_addr = {tgt_addr[254:0], prog_sdi};
          3'd3: lo_q.push_back(prog_sdi);
          3'd4: hi_q.push_back(prog_sdi);
          default: chk(0, "R3 payload after pulse opcode", opc, 0);
        endcase
      end
      if (!prog_mode && p_mode && prog_en) begin
        chk(opc_bits == 3, "R3 opcode length", opc_bits, 3);
        ops_seen.push_back(int'(opc));
        if (opc == 3'd1 || opc == 3'd5) begin in_pulse = 1; pulse_len = 0; pulse_op = opc; end
      end
      p_sclk = prog_sclk; p_mode = prog_mode; p_sdi = prog_sdi; p_en = prog_en;
    end
  end

  task automatic run(input int rows, input int hb, input int ew, input int pw,
                     input int len_adj, input bit extra_start, input int seed);
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    mem[0] = 8'(seed + 8'h5A);
    mem[1] = 8'(ew); mem[2] = 8'(ew >> 8);
    mem[3] = 8'(pw); mem[4] = 8'(pw >> 8);
    mem[5] = 8'(rows); mem[6] = 8'(hb);
    for (int i = 0; i < 2*hb*rows; i++) mem[7+i] = 8'((i*37 + 11) ^ (seed*29));
    mem_len = (AW+1)'(7 + 2*hb*rows + len_adj);
    cur_ew = ew; cur_pw = pw; cur_rows = rows; cur_hb = hb;
    prog_cnt = 0; erase_cnt = 0; en_rises = 0;
    ops_seen.delete(); lo_q.delete(); hi_q.delete();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (extra_start) begin
      repeat (150) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_ops(input int rows, input string tag);
    int exp_q[$];
    int bad;
    exp_q.push_back(1); exp_q.push_back(2);
    for (int r = 0; r < rows; r++) begin
      exp_q.push_back(3); exp_q.push_back(4); exp_q.push_back(5);
      if (r < rows-1) exp_q.push_back(2);
    end
    bad = (exp_q.size() == ops_seen.size()) ? 0 : 1;
    if (bad == 0)
      for (int i = 0; i < exp_q.size(); i++) if (exp_q[i] != ops_seen[i]) bad++;
    chk(bad == 0, tag, ops_seen.size(), exp_q.size());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !error, "R11 reset flags", {busy, done, error}, 0);
    chk(!prog_en && !prog_sclk && !mem_rd, "R11 reset port", {prog_en, prog_sclk, mem_rd}, 0);

    // main pattern, with a second start mid-run
    run(4, 2, 5, 3, 0, 1'b1, 1);
    chk(done && !error, "R11 done after success", {done, error}, 2);
    chk(dev_type == 8'h5B, "R2 device type", dev_type, 8'h5B);
    chk(prog_cnt == 4, "R5 rows programmed", prog_cnt, 4);
    chk(erase_cnt == 1 && en_rises == 1, "R10 no restart on busy start", erase_cnt, 1);
    check_ops(4, "R5 command order");
    chk(!prog_en, "R1 enable low after run", prog_en, 0);

    // single row, zero-width erase, wide halves
    run(1, 3, 0, 1, 0, 1'b0, 2);
    chk(done && !error && prog_cnt == 1, "R5 single row", prog_cnt, 1);
    check_ops(1, "R5 no advance for one row");

    // image one byte short
    run(3, 2, 1, 2, -1, 1'b0, 3);
    chk(error && !done, "R8 short image flags", {done, error}, 1);
    chk(prog_cnt == 2, "R8 incomplete row not programmed", prog_cnt, 2);
    chk(!prog_en, "R8 enable released", prog_en, 0);

    // empty headers
    run(0, 2, 1, 1, 0, 1'b0, 4);
    chk(error && en_rises == 0, "R9 zero rows", en_rises, 0);
    run(2, 0, 1, 1, 0, 1'b0, 5);
    chk(error && en_rises == 0, "R9 zero half length", en_rises, 0);

    // target not ready after erase
    tgt_ready = 1'b0;
    run(2, 1, 2, 1, 0, 1'b0, 6);
    tgt_ready = 1'b1;
    chk(error && !done, "R7 not-ready abort", {done, error}, 1);
    chk(erase_cnt == 1 && prog_cnt == 0 && ops_seen.size() == 1, "R7 nothing after abort",
        ops_seen.size(), 1);

    // a new start clears the error flag
    run(2, 1, 1, 2, 0, 1'b0, 7);
    chk(done && !error && prog_cnt == 2, "R11 flags cleared by start", {done, error}, 2);
    check_ops(2, "R5 command order rerun");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule